// File: doc/BRIEF.md
# DDR Read-Window Leveling Trainer

This block finds where the internal read-enable pulse of one DDR PHY byte lane must sit so that the strobe capture logic frames a read burst correctly. After a start pulse it sends training read requests to the memory controller. It moves the read-enable position through a fixed sweep and samples the burst-detect flag from the capture logic a fixed number of cycles after each read. One memory clock period is one cycle. The capture logic delays the returning strobe by a quarter period before it uses it.

The pulse position has two parts. The coarse part is a pair of cycle offsets, one for the leading half of the pulse and one for the trailing half. Both offsets advance by two cycles together, so the pulse moves one whole two-cycle window per step. The fine part is a 3-bit read-clock select, swept from 0 to 7 inside each window. A setting is accepted only after two back-to-back reads at it both report burst detect. The block then raises done and holds the trained setting. If every select value in every window fails, the block raises done together with an error flag.

Top module: `rdlvl_trainer`

## Requirements
- R1: Out of reset, done, fail and rd_req are 0, rd_clksel is 0, rd_lead_cyc is 0 and rd_trail_cyc is 1.
- R2: Each training read is a one-cycle rd_req pulse. The next read at any setting is issued RD_LAT+1 cycles after the previous one, so done follows the start edge by (RD_LAT+1)·reads+1 cycles.
- R3: burst_det is sampled only in the cycle that lies exactly RD_LAT (default 16) cycles after the rd_req cycle. Its value in any other cycle has no effect.
- R4: Settings are visited in the order setting index = rd_clksel + 8·window, starting from 0. The select runs 0..7 within a window before the window advances. rd_lead_cyc = 2·window and rd_trail_cyc = 2·window+1 at all times.
- R5: A setting passes only after PASS_REQ (default 2) consecutive sampled hits at it. A miss clears the hit count and moves to the next setting.
- R6: On a pass, done=1 and fail=0, and the outputs show the passing setting.
- R7: If N_WIN (default 4) windows are swept without a pass, done=1 and fail=1, and the outputs return to setting 0 (select 0, lead 0, trail 1).
- R8: While done is high, no read is issued. The outputs, done and fail hold their values regardless of burst_det until the next start.
- R9: A start pulse while training is in progress is ignored.
- R10: A start pulse while done is high clears done and fail and restarts the sweep from setting 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one memory clock period per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin training (ignored while busy) |
| burst_det | input | 1 | Correctly framed burst flag from capture logic |
| rd_req | output | 1 | One-cycle training read request |
| rd_clksel | output | 3 | Fine read-clock select |
| rd_lead_cyc | output | 3 | Cycle offset of leading read-enable half |
| rd_trail_cyc | output | 3 | Cycle offset of trailing read-enable half |
| done | output | 1 | Training finished |
| fail | output | 1 | Training finished without a passing setting |

## Verification
The bench plants a decoy setting that hits once and then misses. A design that accepted a single hit, or kept the hit count across settings, would lock onto the decoy or finish one read early. It raises burst_det at random outside the sample cycle, and checks that the number of reads and the cycles to done match the model. A design that sampled one cycle off would then stop at the wrong setting or take the wrong time. Other cases put the passing setting at the last select of a window and at the very last setting, or leave no passing setting at all; these catch wrong wrap order and wrong behavior on a failed sweep. Start pulses during training and noise after done confirm that a restart cannot happen mid-sweep and that the result holds.

// File: rtl/rdlvl_pkg.sv
package rdlvl_pkg;
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} trn_state_t;

  // leading half of the read-enable pulse sits at the start of its 2-cycle window
  function automatic int lead_of(input int win);
    return 2 * win;
  endfunction

  // trailing half follows one cycle later, moving with the leading half
  function automatic int trail_of(input int win);
    return 2 * win + 1;
  endfunction
endpackage

// File: rtl/rdlvl_lat_timer.sv
module rdlvl_lat_timer #(
  parameter int RD_LAT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expire
);
  localparam int CW = $clog2(RD_LAT) + 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (load)  cnt <= '0;
    else if (run)   cnt <= cnt + 1'b1;
  end

  assign expire = run && (cnt == CW'(RD_LAT - 1));
endmodule

// File: rtl/rdlvl_sweep.sv
module rdlvl_sweep #(
  parameter int SEL_W = 3,
  parameter int N_WIN = 4,
  parameter int WIN_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  output logic [SEL_W-1:0] sel,
  output logic [WIN_W-1:0] win,
  output logic             last
);
  localparam logic [SEL_W-1:0] SEL_MAX = '1;
  localparam logic [WIN_W-1:0] WIN_MAX = WIN_W'(N_WIN - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel <= '0;
      win <= '0;
    end else if (clear) begin
      sel <= '0;
      win <= '0;
    end else if (advance) begin
      if (sel == SEL_MAX) begin
        sel <= '0;
        win <= win + 1'b1;
      end else begin
        sel <= sel + 1'b1;
      end
    end
  end

  assign last = (sel == SEL_MAX) && (win == WIN_MAX);
endmodule

// File: rtl/rdlvl_hit_count.sv
module rdlvl_hit_count #(
  parameter int PASS_REQ = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic hit,
  output logic will_pass
);
  localparam int HW = $clog2(PASS_REQ + 1);
  logic [HW-1:0] hits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hits <= '0;
    else if (clear) hits <= '0;
    else if (hit)   hits <= hits + 1'b1;
  end

  assign will_pass = hit && (hits == HW'(PASS_REQ - 1));
endmodule

// File: rtl/rdlvl_trainer.sv
module rdlvl_trainer #(
  parameter int SEL_W    = 3,
  parameter int N_WIN    = 4,
  parameter int RD_LAT   = 16,
  parameter int PASS_REQ = 2,
  parameter int OFS_W    = $clog2(2 * N_WIN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             burst_det,
  output logic             rd_req,
  output logic [SEL_W-1:0] rd_clksel,
  output logic [OFS_W-1:0] rd_lead_cyc,
  output logic [OFS_W-1:0] rd_trail_cyc,
  output logic             done,
  output logic             fail
);
  import rdlvl_pkg::*;
  localparam int WIN_W = (N_WIN > 1) ? $clog2(N_WIN) : 1;

  trn_state_t state, state_nx;
  logic [WIN_W-1:0] win;
  logic sweep_last, tmr_expire, will_pass;
  logic start_train, sample_evt, hit_evt, miss_evt, pass_evt, exhaust_evt, setting_adv;
  logic done_q, fail_q;

  assign start_train = start && (state == S_IDLE || state == S_DONE);
  assign sample_evt  = (state == S_WAIT) && tmr_expire;
  assign hit_evt     = sample_evt && burst_det;
  assign miss_evt    = sample_evt && !burst_det;
  assign pass_evt    = hit_evt && will_pass;
  assign exhaust_evt = miss_evt && sweep_last;
  assign setting_adv = miss_evt && !sweep_last;

  rdlvl_lat_timer #(.RD_LAT(RD_LAT)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .load(state == S_ISSUE), .run(state == S_WAIT),
    .expire(tmr_expire)
  );

  rdlvl_sweep #(.SEL_W(SEL_W), .N_WIN(N_WIN), .WIN_W(WIN_W)) u_sweep (
    .clk(clk), .rst_n(rst_n),
    .clear(start_train || exhaust_evt), .advance(setting_adv),
    .sel(rd_clksel), .win(win), .last(sweep_last)
  );

  rdlvl_hit_count #(.PASS_REQ(PASS_REQ)) u_hits (
    .clk(clk), .rst_n(rst_n),
    .clear(start_train || miss_evt || pass_evt), .hit(hit_evt),
    .will_pass(will_pass)
  );

  always_comb begin
    state_nx = state;
    case (state)
      S_IDLE:  if (start_train) state_nx = S_ISSUE;
      S_ISSUE: state_nx = S_WAIT;
      S_WAIT: begin
        if (pass_evt || exhaust_evt) state_nx = S_DONE;
        else if (sample_evt)         state_nx = S_ISSUE;
      end
      S_DONE:  if (start_train) state_nx = S_ISSUE;
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      done_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      state <= state_nx;
      if (start_train) begin
        done_q <= 1'b0;
        fail_q <= 1'b0;
      end else if (pass_evt) begin
        done_q <= 1'b1;
        fail_q <= 1'b0;
      end else if (exhaust_evt) begin
        done_q <= 1'b1;
        fail_q <= 1'b1;
      end
    end
  end

  assign rd_req       = (state == S_ISSUE);
  assign done         = done_q;
  assign fail         = fail_q;
  assign rd_lead_cyc  = OFS_W'(lead_of(int'(win)));
  assign rd_trail_cyc = OFS_W'(trail_of(int'(win)));
endmodule

// File: rtl/rdlvl_trainer_chk.sv
module rdlvl_trainer_chk #(
  parameter int SEL_W  = 3,
  parameter int OFS_W  = 3,
  parameter int RD_LAT = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             rd_req,
  input logic             sample_evt,
  input logic             done,
  input logic             fail,
  input logic [SEL_W-1:0] rd_clksel,
  input logic [OFS_W-1:0] rd_lead_cyc,
  input logic [OFS_W-1:0] rd_trail_cyc
);
  localparam int AW = $clog2(RD_LAT + 2);
  logic [AW-1:0] since_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          since_rd <= '0;
    else if (rd_req)                     since_rd <= AW'(1);
    else if (since_rd != '0 && since_rd <= AW'(RD_LAT)) since_rd <= since_rd + 1'b1;
  end

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req); // R2
  AST_SAMPLE_AT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    sample_evt |-> (since_rd == AW'(RD_LAT))); // R3
  AST_PAIR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_trail_cyc == rd_lead_cyc + 1'b1); // R4
  AST_FAIL_SETTING_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (rd_clksel == '0 && rd_lead_cyc == '0)); // R7
  AST_DONE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rd_req); // R8
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(fail) && $stable(rd_clksel) && $stable(rd_lead_cyc))); // R8
  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> (!done && rd_req && rd_clksel == '0 && rd_lead_cyc == '0)); // R10
endmodule

bind rdlvl_trainer rdlvl_trainer_chk #(
  .SEL_W(SEL_W), .OFS_W(OFS_W), .RD_LAT(RD_LAT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .rd_req(rd_req),
  .sample_evt(sample_evt), .done(done), .fail(fail),
  .rd_clksel(rd_clksel), .rd_lead_cyc(rd_lead_cyc), .rd_trail_cyc(rd_trail_cyc)
);

// File: tb/rdlvl_trainer_test.sv
`timescale 1ns/1ps
module rdlvl_trainer_test;
  localparam int RD_LAT = 16;
  localparam int NSET   = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic burst_det = 1'b0;
  logic rd_req, done, fail;
  logic [2:0] rd_clksel, rd_lead_cyc, rd_trail_cyc;

  int n_chk = 0, n_err = 0;
  int tgt = NSET, dcy = -1;
  bit noise = 1'b0;
  int reads = 0;
  int exp_idx = 0;
  int reads_at[NSET];

  always #10 clk = ~clk;

  rdlvl_trainer uut (
    .clk(clk), .rst_n(rst_n), .start(start), .burst_det(burst_det),
    .rd_req(rd_req), .rd_clksel(rd_clksel), .rd_lead_cyc(rd_lead_cyc),
    .rd_trail_cyc(rd_trail_cyc), .done(done), .fail(fail)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_reads(input int t, input int d);
    int r;
    r = (t < NSET) ? t + 2 : NSET;
    if (d >= 0 && d < t) r++;
    return r;
  endfunction

  function automatic int exp_latency(input int r);
    return (RD_LAT + 1) * r + 1;
  endfunction

  // memory/capture responder: burst_det is meaningful only RD_LAT cycles after a read
  initial begin
    int age = -1;
    int idx = 0;
    bit hit;
    forever begin
      @(negedge clk);
      burst_det = noise ? 1'($urandom) : 1'b0;
      if (rd_req) begin
        idx = int'(rd_clksel) + 8 * (int'(rd_lead_cyc) / 2);
        reads++;
        chk(idx == exp_idx, "R4 sweep order", idx, exp_idx);
        chk(int'(rd_trail_cyc) == int'(rd_lead_cyc) + 1, "R4 trail offset",
            int'(rd_trail_cyc), int'(rd_lead_cyc) + 1);
        age = 0;
      end else if (age >= 0) begin
        age++;
        if (age == RD_LAT) begin
          hit = (idx == tgt) || (idx == dcy && reads_at[idx] == 0);
          reads_at[idx]++;
          burst_det = hit;
          if (!hit) exp_idx = (idx + 1) % NSET;
          age = -1;
        end
      end
    end
  end

  task automatic run_case(input int t, input int d, input bit nz, input bit poke_start);
    int n = 0;
    int r_exp;
    tgt = t; dcy = d; noise = nz;
    foreach (reads_at[i]) reads_at[i] = 0;
    reads = 0; exp_idx = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0; n = 1;
    while (!done && n < 5000) begin
      @(negedge clk); n++;
      start = (poke_start && n == 40);
    end
    start = 1'b0;
    r_exp = exp_reads(t, d);
    chk(done == 1'b1, "R6/R7 done", int'(done), 1);
    chk(reads == r_exp, "R5 read count", reads, r_exp);
    chk(n == exp_latency(r_exp), "R2/R3 cycles to done", n, exp_latency(r_exp));
    if (t < NSET) begin
      chk(fail == 1'b0, "R6 fail flag", int'(fail), 0);
      chk(int'(rd_clksel) == t % 8, "R6 select", int'(rd_clksel), t % 8);
      chk(int'(rd_lead_cyc) == 2 * (t / 8), "R6 lead", int'(rd_lead_cyc), 2 * (t / 8));
    end else begin
      chk(fail == 1'b1, "R7 fail flag", int'(fail), 1);
      chk(rd_clksel == 3'd0 && rd_lead_cyc == 3'd0 && rd_trail_cyc == 3'd1,
          "R7 setting zero", int'(rd_clksel) + 8 * int'(rd_lead_cyc), 0);
    end
    if (poke_start) chk(reads == r_exp, "R9 start ignored while busy", reads, r_exp);
    // R8: hold under noise
    begin
      logic [2:0] s0, l0;
      logic f0;
      int rd0;
      s0 = rd_clksel; l0 = rd_lead_cyc; f0 = fail; rd0 = reads;
      noise = 1'b1;
      repeat (3 * RD_LAT) @(negedge clk);
      noise = 1'b0;
      chk(done && fail == f0 && rd_clksel == s0 && rd_lead_cyc == l0 && reads == rd0,
          "R8 hold after done", int'(rd_clksel), int'(s0));
    end
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk); wd++;
      if (wd > 150000) begin
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=%0d expected=%0d", wd, 150000);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(!done && !fail && !rd_req, "R1 reset flags", int'(done) + int'(fail) + int'(rd_req), 0);
    chk(rd_clksel == 3'd0 && rd_lead_cyc == 3'd0 && rd_trail_cyc == 3'd1, "R1 reset setting",
        int'(rd_trail_cyc), 1);
    rst_n = 1'b1;
    @(negedge clk);
    run_case(0, -1, 1'b0, 1'b0);      // first setting
    run_case(7, -1, 1'b1, 1'b1);      // last select of window 0, noise, start poke (R9)
    run_case(8, 3, 1'b1, 1'b0);       // window advance with decoy (R5)
    run_case(31, 30, 1'b0, 1'b0);     // very last setting
    run_case(NSET, 5, 1'b1, 1'b0);    // no passing setting (R7)
    // R10: restart straight out of a failed sweep
    run_case(12, -1, 1'b0, 1'b1);
    for (int k = 0; k < 6; k++) begin
      int t, d;
      t = int'($urandom_range(0, NSET));
      d = int'($urandom_range(0, NSET - 1));
      if (d == t) d = -1;
      run_case(t, d, 1'b1, (t > 4));
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule